// File: doc/BRIEF.md
# Programmable Video Timing and Test Pattern Generator

This block produces the raster timing for a display link. Two counters run in the pixel clock domain: a pixel counter that spans one line and a line counter that spans one frame. Run-time configuration inputs set the total length of each axis, the width of its sync pulse and the first and past-the-end positions of its active window. All positions count from zero, and zero is the leading edge of sync. Horizontal sync, vertical sync and data enable are decoded from the two counters and registered.

The pixel carried with data enable comes from one of three sources. The first is a live upstream stream, which the block paces with a request output. The second is a fixed 24-bit colour. The third is a ramp that steps once per active pixel and starts again at every frame. The same timing drives all three sources, so a test image has exactly the geometry of live video.

Top module: `vtg_top`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, `hsync`, `vsync`, `de`, `pixel_out` and `in_req` are all 0. The output registers capture pixel position (0,0) on the third edge.
- R2: The pixel counter counts 0 to `h_total`-1 and then returns to 0. `hsync` is 1 exactly for pixel positions below `h_sync_len`.
- R3: The line counter advances when the pixel counter wraps, and counts 0 to `v_total`-1. `vsync` is 1 exactly for line positions below `v_sync_len`.
- R4: `de` is 1 only when the pixel position is at least `h_de_start` and below `h_de_stop`, and the line position is at least `v_de_start` and below `v_de_stop`.
- R5: With `src_sel` = 2'b11, every active pixel equals `const_rgb`.
- R6: With `src_sel` = 2'b10, the active pixels follow a ramp. The ramp is 0 on the first active pixel of each frame, rises by 1 on each later active pixel and wraps modulo 2^24.
- R7: With `src_sel` = 2'b00 or 2'b01, an active pixel is the `in_pixel` value present in the cycle before it appears. `in_req` is 1 in that cycle and in no other. In the other two modes `in_req` stays 0.
- R8: `pixel_out` is 0 whenever `de` is 0.
- R9: Every output is registered and reflects the counter position one clock earlier. Sync, enable and pixel data therefore stay aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_total | input | 16 | Pixel clocks per line |
| h_sync_len | input | 16 | Horizontal sync width in pixel clocks |
| h_de_start | input | 16 | First active pixel position |
| h_de_stop | input | 16 | Pixel position just past the active region |
| v_total | input | 16 | Lines per frame |
| v_sync_len | input | 16 | Vertical sync width in lines |
| v_de_start | input | 16 | First active line |
| v_de_stop | input | 16 | Line just past the active region |
| src_sel | input | 2 | Pixel source: 0/1 stream, 2 ramp, 3 constant |
| const_rgb | input | 24 | Constant colour |
| in_pixel | input | 24 | Upstream pixel, taken while `in_req` is 1 |
| in_req | output | 1 | Upstream pixel request |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pixel_out | output | 24 | Pixel data |

## Verification
A pixel counter that wraps one position early or late shifts `hsync` and `de` within the first line. The error then grows by one position on every line, so it shows at the ports within a few dozen clocks. A wrong line counter or window compare shows as `vsync` or `de` on the wrong lines within the first frame. A ramp that is not cleared at the frame boundary shows on the first active pixel of the second frame. A request that is not aligned to `de` corrupts the live pixels one clock later.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W_DEF   = 16;
  localparam int PIX_W_DEF   = 24;
  localparam int RST_STAGES  = 2;

  typedef enum logic [1:0] {
    SRC_STREAM_A = 2'd0,
    SRC_STREAM_B = 2'd1,
    SRC_RAMP     = 2'd2,
    SRC_FLAT     = 2'd3
  } src_e;

  function automatic logic src_is_live(input logic [1:0] sel);
    return (sel[1] == 1'b0);
  endfunction
endpackage

// File: rtl/vtg_rst_sync.sv
module vtg_rst_sync #(
  parameter int STAGES = vtg_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int W = vtg_pkg::CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] total,
  input  logic [W-1:0] sync_len,
  input  logic [W-1:0] win_lo,
  input  logic [W-1:0] win_hi,
  output logic [W-1:0] cnt,
  output logic         at_last,
  output logic         in_sync,
  output logic         in_win
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   inc;

  always_comb begin
    inc     = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    at_last = (inc >= {1'b0, total});
    cnt_d   = cnt_q;
    if (adv) cnt_d = at_last ? '0 : inc[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign in_sync = (cnt_q < sync_len);
  assign in_win  = (cnt_q >= win_lo) && (cnt_q < win_hi);
endmodule

// File: rtl/vtg_pixsrc.sv
module vtg_pixsrc #(
  parameter int PIX_W = vtg_pkg::PIX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             frame_end,
  input  logic [1:0]       sel,
  input  logic [PIX_W-1:0] flat_px,
  input  logic [PIX_W-1:0] stream_px,
  output logic [PIX_W-1:0] px_next
);
  import vtg_pkg::*;

  logic [PIX_W-1:0] ramp_q, ramp_d;

  always_comb begin
    ramp_d = ramp_q;
    if (frame_end)   ramp_d = '0;
    else if (active) ramp_d = ramp_q + {{(PIX_W-1){1'b0}}, 1'b1};
  end

  always_comb begin
    px_next = '0;
    if (active) begin
      case (src_e'(sel))
        SRC_FLAT: px_next = flat_px;
        SRC_RAMP: px_next = ramp_q;
        default:  px_next = stream_px;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ramp_q <= '0;
    else        ramp_q <= ramp_d;
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top #(
  parameter int CNT_W = vtg_pkg::CNT_W_DEF,
  parameter int PIX_W = vtg_pkg::PIX_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] h_total,
  input  logic [CNT_W-1:0] h_sync_len,
  input  logic [CNT_W-1:0] h_de_start,
  input  logic [CNT_W-1:0] h_de_stop,
  input  logic [CNT_W-1:0] v_total,
  input  logic [CNT_W-1:0] v_sync_len,
  input  logic [CNT_W-1:0] v_de_start,
  input  logic [CNT_W-1:0] v_de_stop,
  input  logic [1:0]       src_sel,
  input  logic [PIX_W-1:0] const_rgb,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             in_req,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pixel_out
);
  import vtg_pkg::*;

  logic             rst_i;
  logic [CNT_W-1:0] h_cnt, v_cnt;
  logic             h_last, v_last, h_sync, v_sync, h_win, v_win;
  logic             active;
  logic [PIX_W-1:0] px_d;
  logic             hs_d, vs_d, de_d;
  logic             hs_q, vs_q, de_q;
  logic [PIX_W-1:0] px_q;

  vtg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  vtg_axis #(.W(CNT_W)) u_h (
    .clk(clk), .rst_n(rst_i), .adv(1'b1),
    .total(h_total), .sync_len(h_sync_len),
    .win_lo(h_de_start), .win_hi(h_de_stop),
    .cnt(h_cnt), .at_last(h_last), .in_sync(h_sync), .in_win(h_win)
  );

  vtg_axis #(.W(CNT_W)) u_v (
    .clk(clk), .rst_n(rst_i), .adv(h_last),
    .total(v_total), .sync_len(v_sync_len),
    .win_lo(v_de_start), .win_hi(v_de_stop),
    .cnt(v_cnt), .at_last(v_last), .in_sync(v_sync), .in_win(v_win)
  );

  assign active = h_win && v_win;

  vtg_pixsrc #(.PIX_W(PIX_W)) u_px (
    .clk(clk), .rst_n(rst_i), .active(active),
    .frame_end(h_last && v_last), .sel(src_sel),
    .flat_px(const_rgb), .stream_px(in_pixel), .px_next(px_d)
  );

  always_comb begin
    hs_d = h_sync;
    vs_d = v_sync;
    de_d = active;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      px_q <= '0;
    end else begin
      hs_q <= hs_d;
      vs_q <= vs_d;
      de_q <= de_d;
      px_q <= px_d;
    end
  end

  assign in_req    = rst_i && active && src_is_live(src_sel);
  assign hsync     = hs_q;
  assign vsync     = vs_q;
  assign de        = de_q;
  assign pixel_out = px_q;
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int CNT_W = vtg_pkg::CNT_W_DEF,
  parameter int PIX_W = vtg_pkg::PIX_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] h_cnt,
  input logic [CNT_W-1:0] h_total,
  input logic             de,
  input logic             in_req,
  input logic [1:0]       src_sel,
  input logic [PIX_W-1:0] const_rgb,
  input logic [PIX_W-1:0] pixel_out
);
  assert_hwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(h_total) && h_total > 1 && h_cnt == h_total - 1'b1) |=> (h_cnt == '0));

  assert_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(src_sel) == 2'b11 && $stable(const_rgb)) |-> (pixel_out == const_rgb));

  assert_req_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |-> (src_sel[1] == 1'b0));

  assert_req_to_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_req |=> de);

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pixel_out == '0));
endmodule

bind vtg_top vtg_checker #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .h_total(h_total),
  .de(de), .in_req(in_req), .src_sel(src_sel), .const_rgb(const_rgb),
  .pixel_out(pixel_out)
);

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] h_total = 16'd12, h_sync_len = 16'd2, h_de_start = 16'd4, h_de_stop = 16'd10;
  logic [15:0] v_total = 16'd6,  v_sync_len = 16'd1, v_de_start = 16'd2, v_de_stop = 16'd5;
  logic [1:0]  src_sel = 2'b11;
  logic [23:0] const_rgb = 24'hA5C3E1;
  logic [23:0] in_pixel = 24'h123456;
  logic        in_req, hsync, vsync, de;
  logic [23:0] pixel_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct packed {
    logic        hs;
    logic        vs;
    logic        de;
    logic [23:0] px;
    logic        rq;
    logic        early;
  } exp_t;

  exp_t exp_q[$];

  vtg_top u0 (
    .clk(clk), .rst_n(rst_n),
    .h_total(h_total), .h_sync_len(h_sync_len), .h_de_start(h_de_start), .h_de_stop(h_de_stop),
    .v_total(v_total), .v_sync_len(v_sync_len), .v_de_start(v_de_start), .v_de_stop(v_de_stop),
    .src_sel(src_sel), .const_rgb(const_rgb), .in_pixel(in_pixel),
    .in_req(in_req), .hsync(hsync), .vsync(vsync), .de(de), .pixel_out(pixel_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      in_pixel = in_pixel + 24'h010203;
    end
  end

  function automatic bit in_window(input int h, input int v);
    return (h >= int'(h_de_start)) && (h < int'(h_de_stop)) &&
           (v >= int'(v_de_start)) && (v < int'(v_de_stop));
  endfunction

  // Reference model: positions, ramp and request derived from the requirements
  int          mh, mv, edges;
  logic [23:0] mpat;
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      mh = 0; mv = 0; edges = 0; mpat = '0;
    end else begin
      edges++;
      e = '0;
      if (edges <= 2) begin
        e.early = 1'b1;
        e.rq = (edges == 2) && !src_sel[1] && in_window(0, 0);
      end else begin
        bit hl, vl;
        e.hs = (mh < int'(h_sync_len));
        e.vs = (mv < int'(v_sync_len));
        e.de = in_window(mh, mv);
        if (e.de) e.px = (src_sel == 2'b11) ? const_rgb :
                         (src_sel == 2'b10) ? mpat : in_pixel;
        hl = (mh + 1 >= int'(h_total));
        vl = (mv + 1 >= int'(v_total));
        if (hl && vl)  mpat = '0;
        else if (e.de) mpat = mpat + 24'd1;
        if (hl) begin
          mh = 0;
          mv = vl ? 0 : mv + 1;
        end else begin
          mh = mh + 1;
        end
        e.rq = !src_sel[1] && in_window(mh, mv);
      end
      exp_q.push_back(e);
    end
  end

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (e.early && {hsync, vsync, de, pixel_out} != '0) begin
        n_fail++;
        $display("FAIL R1 outputs after release got %b%b%b %h expected 0", hsync, vsync, de, pixel_out);
      end else if (hsync != e.hs) begin
        n_fail++;
        $display("FAIL R2 hsync got %b expected %b", hsync, e.hs);
      end else if (vsync != e.vs) begin
        n_fail++;
        $display("FAIL R3 vsync got %b expected %b", vsync, e.vs);
      end else if (de != e.de) begin
        n_fail++;
        $display("FAIL R4 de got %b expected %b", de, e.de);
      end else if (pixel_out != e.px) begin
        n_fail++;
        if (!e.de)
          $display("FAIL R8 blank pixel got %h expected %h", pixel_out, e.px);
        else if (src_sel == 2'b11)
          $display("FAIL R5 constant pixel got %h expected %h", pixel_out, e.px);
        else if (src_sel == 2'b10)
          $display("FAIL R6 ramp pixel got %h expected %h", pixel_out, e.px);
        else
          $display("FAIL R7 stream pixel got %h expected %h", pixel_out, e.px);
      end else if (in_req != e.rq) begin
        n_fail++;
        $display("FAIL R7 in_req got %b expected %b", in_req, e.rq);
      end
    end
  end

  task automatic run_case(input int ht, input int hs, input int hb, input int he,
                          input int vt, input int vs, input int vb, input int ve,
                          input logic [1:0] sel, input logic [23:0] c, input int cycles);
    @(posedge clk);
    #1;
    exp_q.delete();
    rst_n = 1'b0;
    h_total = 16'(ht); h_sync_len = 16'(hs); h_de_start = 16'(hb); h_de_stop = 16'(he);
    v_total = 16'(vt); v_sync_len = 16'(vs); v_de_start = 16'(vb); v_de_stop = 16'(ve);
    src_sel = sel; const_rgb = c;
    @(negedge clk);
    n_checks++;
    if ({hsync, vsync, de, pixel_out, in_req} != '0) begin
      n_fail++;
      $display("FAIL R1 reset state got %b%b%b %h %b expected all 0", hsync, vsync, de, pixel_out, in_req);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    // R5 constant colour, R2/R3/R4 timing, R8 blanking
    run_case(12, 2, 4, 10, 6, 1, 2, 5, 2'b11, 24'hA5C3E1, 170);
    // R6 ramp over two frames, restart at frame boundary
    run_case(12, 2, 4, 10, 6, 1, 2, 5, 2'b10, 24'h000000, 170);
    // R7 live stream with request, mode 0
    run_case(12, 3, 5, 11, 6, 2, 1, 4, 2'b00, 24'h000000, 170);
    // R6 window starting at position (0,0), R9 alignment
    run_case(8, 1, 0, 5, 5, 1, 0, 3, 2'b10, 24'h000000, 110);
    // R7 live stream mode 1, request reaching position (0,0)
    run_case(9, 2, 0, 9, 4, 1, 0, 4, 2'b01, 24'h000000, 90);
    // R5 constant in a window ending at the line end, R7 request stays low
    run_case(10, 4, 6, 10, 7, 3, 4, 7, 2'b11, 24'h00FF7E, 160);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    exp_q.delete();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule